// File: doc/BRIEF.md
# Ping-Pong Amplifier Offset Trim Controller

This block is the digital half of an offset trim loop shared by two interchangeable residue amplifiers. At any time one amplifier carries the live signal and the other is off line. A start request begins a trim of the off-line amplifier. The controller presets that amplifier's trim code to mid-scale. On each evaluation strobe it reads two comparator decisions and moves the code one step up or down, or leaves it where it is.

When the comparators report in-band on enough consecutive strobes, the loop is locked. The code then freezes in that amplifier's holding register, and one clock later the path select flips. This puts the freshly trimmed amplifier into the data path, and the next start request trims the other one. If the loop never settles, a strobe budget runs out. The controller then raises an error flag, freezes the code and leaves the path alone. Each amplifier's code output stays valid after its trim has ended.

Top module: `cal_pingpong_ctrl`

## Requirements
- R1: After reset both code outputs are 512, `path_sel_o` is 0, and `busy_o`, `lock_o` and `timeout_o` are 0. A start request is accepted only while idle and with no swap pending. Acceptance sets `busy_o`, clears both flags and presets the trim code of amplifier `!path_sel_o` to 512 on the same edge.
- R2: While busy, each cycle with `eval_i` high changes the trimmed code by one step. Up=1, dn=0 adds 1. Up=0, dn=1 subtracts 1. Both low or both high leaves the code unchanged. Cycles with `eval_i` low change nothing.
- R3: The trimmed code saturates at 0 and at 1023 and never wraps.
- R4: A hold decision (both low or both high) on 4 consecutive strobes sets `lock_o` and clears `busy_o` on the edge of the 4th strobe. Any step decision restarts the count. After that, neither code changes until the next accepted start.
- R5: The code of the amplifier in the data path (`path_sel_o ? code1_o : code0_o`) never changes while busy.
- R6: `path_sel_o` toggles on the clock edge after the one that set `lock_o`, and at no other time.
- R7: If the 2048th strobe since start does not produce lock, `timeout_o` is set and `busy_o` is cleared on that edge. That strobe's step still applies. The code then freezes and `path_sel_o` is not toggled.
- R8: `lock_o` and `timeout_o` are never high together, and they hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a trim of the off-line amplifier |
| eval_i | input | 1 | Comparator decisions valid this cycle |
| cmp_up_i | input | 1 | Comparator asking for a higher code |
| cmp_dn_i | input | 1 | Comparator asking for a lower code |
| code0_o | output | 10 | Trim code of amplifier 0 |
| code1_o | output | 10 | Trim code of amplifier 1 |
| path_sel_o | output | 1 | Amplifier in the data path (0 or 1) |
| busy_o | output | 1 | Trim in progress |
| lock_o | output | 1 | Last trim ended in lock |
| timeout_o | output | 1 | Last trim ran out of strobes |

## Verification
The timeout path is the hardest state to reach. Its 2048-strobe budget must pass without four consecutive hold decisions ever appearing, and random comparator traffic almost always locks first. The bench drives it with a directed run of strictly alternating up and down decisions. It reaches the saturation rails with a directed run of 520 up steps, and then runs 520 down steps on the next trim. Random trims model a comparator pair tracking a random target code with occasional noise flips and sparse strobes. A bench reference model is compared against every output on every cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DN   = 2'd2
  } cal_dec_e;
endpackage

// File: rtl/cal_decode.sv
module cal_decode
  import cal_pkg::*;
(
  input  logic     up_i,
  input  logic     dn_i,
  output cal_dec_e dec_o
);
  always_comb begin
    unique case ({up_i, dn_i})
      2'b10:   dec_o = DEC_UP;
      2'b01:   dec_o = DEC_DN;
      default: dec_o = DEC_HOLD; // in-band or illegal
    endcase
  end
endmodule

// File: rtl/cal_sat_step.sv
module cal_sat_step
  import cal_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] code_i,
  input  cal_dec_e          dec_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MAX_C = {CODE_W{1'b1}};

  always_comb begin
    code_o = code_i;
    case (dec_i)
      DEC_UP:  if (code_i != MAX_C) code_o = code_i + 1'b1;
      DEC_DN:  if (code_i != '0)    code_o = code_i - 1'b1;
      default: code_o = code_i;
    endcase
  end
endmodule

// File: rtl/cal_progress.sv
module cal_progress #(
  parameter int LOCK_CNT = 4,
  parameter int TIMEOUT  = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic eval_i,
  input  logic hold_i,
  output logic lock_hit_o,
  output logic to_hit_o
);
  localparam int HW = $clog2(LOCK_CNT + 1);
  localparam int SW = $clog2(TIMEOUT + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(LOCK_CNT - 1);
  localparam logic [SW-1:0] STRB_LAST = SW'(TIMEOUT - 1);

  logic [HW-1:0] hold_q;
  logic [SW-1:0] strb_q;

  assign lock_hit_o = eval_i && hold_i && (hold_q == HOLD_LAST);
  assign to_hit_o   = eval_i && !lock_hit_o && (strb_q == STRB_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      strb_q <= '0;
    end else if (clear_i) begin
      hold_q <= '0;
      strb_q <= '0;
    end else if (eval_i) begin
      hold_q <= hold_i ? hold_q + 1'b1 : '0;
      strb_q <= strb_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_pingpong_ctrl.sv
module cal_pingpong_ctrl
  import cal_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int LOCK_CNT = 4,
  parameter int TIMEOUT  = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eval_i,
  input  logic              cmp_up_i,
  input  logic              cmp_dn_i,
  output logic [CODE_W-1:0] code0_o,
  output logic [CODE_W-1:0] code1_o,
  output logic              path_sel_o,
  output logic              busy_o,
  output logic              lock_o,
  output logic              timeout_o
);
  localparam logic [CODE_W-1:0] MID_C = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_q [2];
  logic              path_q, busy_q, lock_q, to_q, swap_q;
  logic              start_acc, ev_act, tgt;
  logic              lock_hit, to_hit;
  cal_dec_e          dec;
  logic [CODE_W-1:0] code_nxt;

  assign tgt       = ~path_q;
  assign start_acc = start_i && !busy_q && !swap_q;
  assign ev_act    = busy_q && eval_i;

  cal_decode i_dec (.up_i(cmp_up_i), .dn_i(cmp_dn_i), .dec_o(dec));

  cal_sat_step #(.CODE_W(CODE_W)) i_step (
    .code_i(code_q[tgt]), .dec_i(dec), .code_o(code_nxt)
  );

  cal_progress #(.LOCK_CNT(LOCK_CNT), .TIMEOUT(TIMEOUT)) i_prog (
    .clk_i, .rst_ni,
    .clear_i   (start_acc),
    .eval_i    (ev_act),
    .hold_i    (dec == DEC_HOLD),
    .lock_hit_o(lock_hit),
    .to_hit_o  (to_hit)
  );

  for (genvar a = 0; a < 2; a++) begin : g_amp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               code_q[a] <= MID_C;
      else if (tgt == a[0] && start_acc)         code_q[a] <= MID_C;
      else if (tgt == a[0] && ev_act)            code_q[a] <= code_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q <= 1'b0;
      busy_q <= 1'b0;
      lock_q <= 1'b0;
      to_q   <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      if (swap_q) begin
        path_q <= ~path_q;
        swap_q <= 1'b0;
      end
      if (start_acc) begin
        busy_q <= 1'b1;
        lock_q <= 1'b0;
        to_q   <= 1'b0;
      end else if (lock_hit) begin
        busy_q <= 1'b0;
        lock_q <= 1'b1;
        swap_q <= 1'b1;
      end else if (to_hit) begin
        busy_q <= 1'b0;
        to_q   <= 1'b1;
      end
    end
  end

  assign code0_o    = code_q[0];
  assign code1_o    = code_q[1];
  assign path_sel_o = path_q;
  assign busy_o     = busy_q;
  assign lock_o     = lock_q;
  assign timeout_o  = to_q;
endmodule

// File: rtl/cal_pingpong_chk.sv
module cal_pingpong_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              eval_i,
  input logic              cmp_up_i,
  input logic              cmp_dn_i,
  input logic [CODE_W-1:0] code0_o,
  input logic [CODE_W-1:0] code1_o,
  input logic              path_sel_o,
  input logic              busy_o,
  input logic              lock_o,
  input logic              timeout_o
);
  localparam logic [CODE_W-1:0] MAX_C = {CODE_W{1'b1}};
  logic [CODE_W-1:0] trim_c, live_c;
  assign trim_c = path_sel_o ? code0_o : code1_o;
  assign live_c = path_sel_o ? code1_o : code0_o;

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (trim_c == $past(trim_c)) || (trim_c == $past(trim_c) + 1'b1)
            || (trim_c == $past(trim_c) - 1'b1)); // R2
  AST_NO_STROBE_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !eval_i) |=> $stable(trim_c)); // R2
  AST_SAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && eval_i && cmp_up_i && !cmp_dn_i && trim_c == MAX_C) |=> trim_c == MAX_C); // R3
  AST_SAT_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && eval_i && cmp_dn_i && !cmp_up_i && trim_c == '0) |=> trim_c == '0); // R3
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(code0_o) && $stable(code1_o))); // R4
  AST_LIVE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(live_c)); // R5
  AST_SWAP_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |=> (path_sel_o != $past(path_sel_o))); // R6
  AST_NO_SWAP_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |=> $stable(path_sel_o)); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lock_o && timeout_o)); // R8
endmodule

bind cal_pingpong_ctrl cal_pingpong_chk #(.CODE_W(CODE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .eval_i(eval_i),
  .cmp_up_i(cmp_up_i), .cmp_dn_i(cmp_dn_i), .code0_o(code0_o), .code1_o(code1_o),
  .path_sel_o(path_sel_o), .busy_o(busy_o), .lock_o(lock_o), .timeout_o(timeout_o)
);

// File: tb/test_cal_pingpong_ctrl.sv
module test_cal_pingpong_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ev = 0, up = 0, dn = 0;
  logic [9:0] c0, c1;
  logic psel, busy, lock, tout;
  int errs = 0, checks = 0, ncyc = 0;

  always #4 clk = ~clk;

  cal_pingpong_ctrl i_cal_pingpong_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .eval_i(ev),
    .cmp_up_i(up), .cmp_dn_i(dn), .code0_o(c0), .code1_o(c1),
    .path_sel_o(psel), .busy_o(busy), .lock_o(lock), .timeout_o(tout)
  );

  // reference model
  int m_code[2];
  bit m_path, m_busy, m_lock, m_to, m_swap;
  int m_hold, m_strb;

  function automatic int step_code(int c, bit u, bit d);
    if (u && !d) return (c < 1023) ? c + 1 : c;
    if (d && !u) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all();
    chk("R2/R3 code0", int'(c0), m_code[0]);
    chk("R2/R3 code1", int'(c1), m_code[1]);
    chk("R6 path_sel", int'(psel), int'(m_path));
    chk("R1 busy", int'(busy), int'(m_busy));
    chk("R4 lock", int'(lock), int'(m_lock));
    chk("R7 timeout", int'(tout), int'(m_to));
  endtask

  task automatic cyc(bit s, bit e, bit u, bit d);
    bit tgt, acc, hold;
    @(negedge clk);
    start = s; ev = e; up = u; dn = d;
    @(posedge clk);
    tgt = !m_path;
    acc = s && !m_busy && !m_swap;
    if (m_swap) begin m_path = !m_path; m_swap = 0; end
    if (acc) begin
      m_busy = 1; m_lock = 0; m_to = 0; m_code[tgt] = 512; m_hold = 0; m_strb = 0;
    end else if (m_busy && e) begin
      hold = (u == d);
      m_code[tgt] = step_code(m_code[tgt], u, d);
      m_hold = hold ? m_hold + 1 : 0;
      m_strb++;
      if (hold && m_hold == 4) begin m_busy = 0; m_lock = 1; m_swap = 1; end
      else if (m_strb == 2048) begin m_busy = 0; m_to = 1; end
    end
    #2;
    chk_all();
  endtask

  task automatic random_trim(int tgt_val);
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 3000 && m_busy; k++) begin
      bit e = ($urandom % 4) != 0;
      bit u = m_code[!m_path] < tgt_val;
      bit d = m_code[!m_path] > tgt_val;
      if (($urandom % 16) == 0) begin u = ~u; end
      if (($urandom % 32) == 0) begin d = 1; u = 1; end
      cyc(0, e, u, d);
    end
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    int sw_path;
    void'($urandom(32'd2024));
    m_code[0] = 512; m_code[1] = 512;
    m_path = 0; m_busy = 0; m_lock = 0; m_to = 0; m_swap = 0; m_hold = 0; m_strb = 0;
    repeat (3) @(posedge clk);
    #2;
    chk_all(); // R1 reset state
    rst_n = 1'b1;
    cyc(0, 1, 1, 0); // R2 strobe while idle: ignored
    // directed: two ups, hold broken by a step (R4), illegal counts as hold
    cyc(1, 0, 0, 0);
    cyc(1, 1, 1, 0); // R1 start while busy ignored
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 1); // R2 no strobe, no move
    cyc(0, 1, 0, 0); cyc(0, 1, 1, 1); cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 1); // R4 step restarts hold count
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 1, 1);
    cyc(0, 1, 0, 0); // 4th hold: lock
    chk("R4 lock set", int'(lock), 1);
    sw_path = int'(psel);
    cyc(0, 1, 1, 0); // R6 swap this edge; R4 frozen
    chk("R6 toggled", int'(psel), 1 - sw_path);
    cyc(0, 1, 0, 1);
    // R3 saturation high on amp 0, then low on amp 1
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 520; k++) cyc(0, 1, 1, 0);
    chk("R3 top rail", int'(c0), 1023);
    repeat (4) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 520; k++) cyc(0, 1, 0, 1);
    chk("R3 bottom rail", int'(c1), 0);
    chk("R5 live code held", int'(c0), 1023);
    repeat (4) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    // R7 timeout: alternate up/down, never four holds
    sw_path = int'(psel);
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 2050; k++) cyc(0, 1, k[0], !k[0]);
    chk("R7 timeout set", int'(tout), 1);
    chk("R7 no swap", int'(psel), sw_path);
    chk("R8 flags exclusive", int'(lock & tout), 0);
    cyc(0, 0, 0, 0);
    // random trims
    for (int n = 0; n < 12; n++) random_trim(int'($urandom % 1024));
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", ncyc);
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end
endmodule